// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block collects eight interrupt request lines, ranks them by fixed priority and raises one interrupt output toward a processor. The processor answers with an acknowledge pulse, and one cycle later the block presents an 8-bit vector that identifies the granted line. Lines are edge-triggered. A rising edge latches a request, and the request stays pending until an acknowledge grants it.

Software reaches the block through two byte-wide addresses on one write port and one combinational read port. The select input picks between them: 0 is the command address and 1 is the data address. A command byte with bit 4 set restarts configuration. The next three data writes then load the vector base, the cascade word and the mode word, in that order. After that, data writes load the line mask. Command bytes choose what the command address reads back, and they retire in-service bits one line at a time. If mode bit 1 is set, a grant never enters the in-service register.

If an acknowledge finds no eligible request, the block reports a spurious interrupt. It returns the vector of line 7 and does not change the in-service register.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, irq_out and vec_valid are low, the mask reads 0xFF at the data address, and the command address reads the pending register, which holds 0x00.
- R2: A command write with bit 4 set enters configuration and clears the mask, the in-service register and the read select, which returns to pending. The next three data writes load the base, the cascade word and the mode word, in that order. irq_out stays low until the mode word has been taken. Command 0x0C makes command-address reads return the cascade word.
- R3: vec_valid is high in the cycle after each acknowledge cycle and low otherwise. vec_out then equals base + n modulo 256, where n is the granted line.
- R4: In normal operation a data write loads the mask (bit n set masks line n), and a data read returns the mask. A masked pending line does not raise irq_out.
- R5: Command 0x0A selects the pending register and command 0x0B selects the in-service register for command-address reads.
- R6: A rising edge on line n sets pending bit n. A line held high does not set the bit again after it has been granted.
- R7: irq_out is high only when configuration is complete and some unmasked pending line has a lower index than every set in-service bit. Line 0 has the highest priority.
- R8: On acknowledge, the lowest-indexed eligible pending bit is cleared and its in-service bit is set.
- R9: Command 0x60+n clears in-service bit n and leaves the other bits unchanged.
- R10: When mode bit 1 is set, an acknowledge leaves the in-service register unchanged.
- R11: An acknowledge with no eligible request returns base + 7 and leaves both the in-service and the pending registers unchanged. This also holds when line 7 is masked.
- R12: A rising edge in the same cycle as the acknowledge that grants that line leaves the line pending. A specific EOI in the same cycle as an acknowledge takes effect together with the new in-service bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Address select: 0 command, 1 data |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the selected address |
| irq_lines | input | 8 | Interrupt request lines, edge-sensitive |
| irq_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge, one cycle per grant |
| vec_valid | output | 1 | Vector valid, the cycle after the acknowledge |
| vec_out | output | 8 | Vector of the granted or spurious line |

## Verification
Two functions can fall in the same cycle. An acknowledge can coincide with a specific EOI written by software, and it can coincide with a fresh rising edge on the very line being granted. The bench provokes both in one cycle: it drops line 2, then raises it again in the acknowledge cycle while writing 0x65. It then expects vector base+2, an in-service register of exactly bit 2, and bit 2 still pending. The cycle-accurate reference model also judges every other cycle, so any ordering error in the merge of set, clear and latch shows up as a mismatch.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VIC_DW = 8;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_BASE  = 2'd1,
        ST_CASC  = 2'd2,
        ST_MODE  = 2'd3
    } vic_state_e;

    typedef enum logic [1:0] {
        RS_PEND = 2'd0,
        RS_SERV = 2'd1,
        RS_CASC = 2'd2
    } vic_rsel_e;

    localparam logic [VIC_DW-1:0] CMD_SEL_PEND = 8'h0A;
    localparam logic [VIC_DW-1:0] CMD_SEL_SERV = 8'h0B;
    localparam logic [VIC_DW-1:0] CMD_SEL_CASC = 8'h0C;
    localparam logic [4:0]        CMD_EOI_TAG  = 5'b01100;
    localparam int                CMD_INIT_BIT = 4;
    localparam int                MODE_AUTO_BIT = 1;
endpackage

// File: rtl/vic_edge_detect.sv
module vic_edge_detect #(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lines,
    output logic [NLINES-1:0] rise
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lines[i];
        end
        assign rise[i] = lines[i] & ~prev_q;
    end
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
    parameter int NLINES = 8,
    localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic [NLINES-1:0] req,
    output logic              any,
    output logic [IW-1:0]     idx,
    output logic [NLINES-1:0] onehot
);
    always_comb begin
        idx = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any    = |req;
        onehot = any ? (NLINES'(1) << idx) : '0;
    end
endmodule

// File: rtl/vic_cmd_decode.sv
module vic_cmd_decode
    import vic_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [VIC_DW-1:0] bus_wdata,
    output logic              do_init,
    output logic              do_sel_pend,
    output logic              do_sel_serv,
    output logic              do_sel_casc,
    output logic              do_eoi,
    output logic [IW-1:0]     eoi_idx,
    output logic              do_data
);
    logic cmd_wr;

    always_comb begin
        cmd_wr      = bus_wr && !bus_sel;
        do_data     = bus_wr && bus_sel;
        do_init     = cmd_wr && bus_wdata[CMD_INIT_BIT];
        do_sel_pend = cmd_wr && !do_init && (bus_wdata == CMD_SEL_PEND);
        do_sel_serv = cmd_wr && !do_init && (bus_wdata == CMD_SEL_SERV);
        do_sel_casc = cmd_wr && !do_init && (bus_wdata == CMD_SEL_CASC);
        do_eoi      = cmd_wr && !do_init && (bus_wdata[VIC_DW-1:3] == CMD_EOI_TAG);
        eoi_idx     = bus_wdata[IW-1:0];
    end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [VIC_DW-1:0] bus_wdata,
    output logic [VIC_DW-1:0] bus_rdata,
    input  logic [NLINES-1:0] irq_lines,
    output logic              irq_out,
    input  logic              int_ack,
    output logic              vec_valid,
    output logic [VIC_DW-1:0] vec_out
);
    typedef struct packed {
        vic_state_e        st;
        vic_rsel_e         rsel;
        logic [NLINES-1:0] irr;
        logic [NLINES-1:0] isr;
        logic [NLINES-1:0] mask;
        logic [VIC_DW-1:0] base;
        logic [VIC_DW-1:0] casc;
        logic [VIC_DW-1:0] mode;
        logic [VIC_DW-1:0] vec;
        logic              vv;
    } vic_regs_t;

    vic_regs_t r_q, r_d;

    logic [NLINES-1:0] rise;
    logic              do_init, do_sel_pend, do_sel_serv, do_sel_casc, do_eoi, do_data;
    logic [IW-1:0]     eoi_idx;
    logic              s_any, g_any;
    logic [IW-1:0]     s_idx, g_idx;
    logic [NLINES-1:0] s_onehot, g_onehot;
    logic [NLINES-1:0] below, elig, grant, isr_work;

    vic_edge_detect #(.NLINES(NLINES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq_lines),
        .rise  (rise)
    );

    vic_cmd_decode #(.NLINES(NLINES)) u_dec (
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .do_init     (do_init),
        .do_sel_pend (do_sel_pend),
        .do_sel_serv (do_sel_serv),
        .do_sel_casc (do_sel_casc),
        .do_eoi      (do_eoi),
        .eoi_idx     (eoi_idx),
        .do_data     (do_data)
    );

    // lowest-indexed in-service bit sets the priority ceiling
    vic_prio_pick #(.NLINES(NLINES)) u_serv_pick (
        .req    (r_q.isr),
        .any    (s_any),
        .idx    (s_idx),
        .onehot (s_onehot)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_below
        assign below[i] = !s_any || (IW'(i) < s_idx);
    end

    assign elig = r_q.irr & ~r_q.mask & below;

    vic_prio_pick #(.NLINES(NLINES)) u_req_pick (
        .req    (elig),
        .any    (g_any),
        .idx    (g_idx),
        .onehot (g_onehot)
    );

    always_comb begin
        r_d      = r_q;
        r_d.vv   = 1'b0;
        grant    = (int_ack && g_any) ? g_onehot : '0;

        // pending: grant clears, a fresh edge sets (edge wins)
        r_d.irr  = (r_q.irr & ~grant) | rise;

        isr_work = r_q.isr;
        if (do_eoi) isr_work[eoi_idx] = 1'b0;
        if (!r_q.mode[MODE_AUTO_BIT]) isr_work = isr_work | grant;
        r_d.isr  = isr_work;

        if (int_ack) begin
            r_d.vv  = 1'b1;
            r_d.vec = r_q.base + (g_any ? VIC_DW'(g_idx) : VIC_DW'(NLINES - 1));
        end

        if (do_sel_pend) r_d.rsel = RS_PEND;
        if (do_sel_serv) r_d.rsel = RS_SERV;
        if (do_sel_casc) r_d.rsel = RS_CASC;

        if (do_data) begin
            unique case (r_q.st)
                ST_BASE: begin r_d.base = bus_wdata; r_d.st = ST_CASC;  end
                ST_CASC: begin r_d.casc = bus_wdata; r_d.st = ST_MODE;  end
                ST_MODE: begin r_d.mode = bus_wdata; r_d.st = ST_READY; end
                default: r_d.mask = bus_wdata[NLINES-1:0];
            endcase
        end

        if (do_init) begin
            r_d.st   = ST_BASE;
            r_d.mask = '0;
            r_d.isr  = '0;
            r_d.rsel = RS_PEND;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_READY;
            r_q.rsel <= RS_PEND;
            r_q.irr  <= '0;
            r_q.isr  <= '0;
            r_q.mask <= '1;
            r_q.base <= '0;
            r_q.casc <= '0;
            r_q.mode <= '0;
            r_q.vec  <= '0;
            r_q.vv   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (bus_sel) begin
            bus_rdata = VIC_DW'(r_q.mask);
        end else begin
            unique case (r_q.rsel)
                RS_SERV: bus_rdata = VIC_DW'(r_q.isr);
                RS_CASC: bus_rdata = r_q.casc;
                default: bus_rdata = VIC_DW'(r_q.irr);
            endcase
        end
    end

    assign irq_out   = (r_q.st == ST_READY) && g_any;
    assign vec_valid = r_q.vv;
    assign vec_out   = r_q.vec;

    // ---------------- assertions ----------------
    assert_ack_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> vec_valid);

    assert_no_ack_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack |=> !vec_valid);

    assert_init_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel && bus_wdata[CMD_INIT_BIT]) |=> !irq_out);

    assert_eoi_one_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel && bus_wdata[VIC_DW-1:3] == CMD_EOI_TAG && !int_ack)
        |=> r_q.isr == ($past(r_q.isr) & ~(NLINES'(1) << $past(bus_wdata[IW-1:0]))));

    assert_auto_eoi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && r_q.mode[MODE_AUTO_BIT] && !bus_wr) |=> $stable(r_q.isr));

    assert_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !g_any && !bus_wr)
        |=> (vec_out == $past(r_q.base) + VIC_DW'(NLINES - 1)) && $stable(r_q.isr));

    assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(g_onehot));
endmodule

// File: tb/vic_ctrl_bench.sv
module vic_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] irq_lines = 8'h00;
    logic       irq_out;
    logic       int_ack = 1'b0;
    logic       vec_valid;
    logic [7:0] vec_out;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    vic_ctrl u_vic_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lines (irq_lines),
        .irq_out   (irq_out),
        .int_ack   (int_ack),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    // behavioural reference model
    int         m_state = 0;   // 0 ready, 1 base, 2 cascade, 3 mode
    int         m_rsel  = 0;   // 0 pending, 1 in-service, 2 cascade
    logic [7:0] m_irr = 8'h00, m_isr = 8'h00, m_mask = 8'hFF;
    logic [7:0] m_base = 8'h00, m_casc = 8'h00, m_mode = 8'h00;
    logic [7:0] m_prev = 8'h00, m_vec = 8'h00;
    logic       m_vv = 1'b0;

    function automatic int m_pick();
        int ceiling = 8;
        int g = -1;
        for (int i = 7; i >= 0; i--) if (m_isr[i]) ceiling = i;
        for (int i = 0; i < ceiling; i++)
            if (g < 0 && m_irr[i] && !m_mask[i]) g = i;
        return g;
    endfunction

    function automatic logic [7:0] m_rdata(input logic sel);
        if (sel) return m_mask;
        if (m_rsel == 1) return m_isr;
        if (m_rsel == 2) return m_casc;
        return m_irr;
    endfunction

    task automatic model_update();
        int         g = m_pick();
        logic [7:0] grant = 8'h00;
        logic [7:0] n_isr = m_isr;
        logic [7:0] n_irr, n_mask = m_mask;
        int         n_state = m_state, n_rsel = m_rsel;
        logic [7:0] n_base = m_base, n_casc = m_casc, n_mode = m_mode;
        m_vv = 1'b0;
        if (int_ack) begin
            m_vv = 1'b1;
            if (g >= 0) begin
                grant[g] = 1'b1;
                m_vec = m_base + 8'(g);
            end else begin
                m_vec = m_base + 8'd7;
            end
        end
        n_irr = (m_irr & ~grant) | (irq_lines & ~m_prev);
        if (bus_wr && !bus_sel && !bus_wdata[4]) begin
            if (bus_wdata == 8'h0A) n_rsel = 0;
            if (bus_wdata == 8'h0B) n_rsel = 1;
            if (bus_wdata == 8'h0C) n_rsel = 2;
            if (bus_wdata[7:3] == 5'b01100) n_isr[bus_wdata[2:0]] = 1'b0;
        end
        if (!m_mode[1]) n_isr = n_isr | grant;
        if (bus_wr && bus_sel) begin
            case (m_state)
                1: begin n_base = bus_wdata; n_state = 2; end
                2: begin n_casc = bus_wdata; n_state = 3; end
                3: begin n_mode = bus_wdata; n_state = 0; end
                default: n_mask = bus_wdata;
            endcase
        end
        if (bus_wr && !bus_sel && bus_wdata[4]) begin
            n_state = 1; n_mask = 8'h00; n_isr = 8'h00; n_rsel = 0;
        end
        m_irr = n_irr; m_isr = n_isr; m_mask = n_mask; m_state = n_state;
        m_rsel = n_rsel; m_base = n_base; m_casc = n_casc; m_mode = n_mode;
        m_prev = irq_lines;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        check("R7 irq_out vs model", 8'(irq_out), 8'((m_state == 0) && (m_pick() >= 0)));
        check("R3 vec_valid vs model", 8'(vec_valid), 8'(m_vv));
        if (m_vv) check("R3 vec_out vs model", vec_out, m_vec);
        check(bus_sel ? "R4 data read vs model" : "R5 command read vs model",
              bus_rdata, m_rdata(bus_sel));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_model();
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        bus_sel = sel; bus_wdata = data; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string req);
        bus_sel = sel;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic ack(input logic [7:0] exp, input string req);
        int_ack = 1'b1;
        cyc();
        int_ack = 1'b0;
        check(req, vec_out, exp);
        check(req, 8'(vec_valid), 8'h01);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 irq_out", 8'(irq_out), 8'h00);
        check("R1 vec_valid", 8'(vec_valid), 8'h00);
        rd(1'b1, 8'hFF, "R1 mask after reset");
        rd(1'b0, 8'h00, "R1 pending after reset");
        cyc();

        // R2 configuration sequence, line 3 raised mid-sequence
        wr(1'b0, 8'h11);
        irq_lines = 8'h08;
        wr(1'b1, 8'h30);
        wr(1'b1, 8'h04);
        check("R2 irq held low in config", 8'(irq_out), 8'h00);
        wr(1'b1, 8'h01);
        check("R7 irq after config", 8'(irq_out), 8'h01);
        rd(1'b1, 8'h00, "R2 mask cleared");
        rd(1'b0, 8'h08, "R6 line 3 pending");
        wr(1'b0, 8'h0C);
        rd(1'b0, 8'h04, "R2 cascade readback");
        wr(1'b0, 8'h0A);

        // R3/R8 first grant
        ack(8'h33, "R3 vector line 3");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h08, "R8 in-service line 3");
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h00, "R6 held line no retrigger");

        // R7 priority ceiling
        irq_lines = 8'h28;
        cyc();
        check("R7 lower priority blocked", 8'(irq_out), 8'h00);
        irq_lines = 8'h2A;
        cyc();
        check("R7 higher priority passes", 8'(irq_out), 8'h01);
        ack(8'h31, "R8 vector line 1");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h0A, "R5 in-service select");

        // R9 specific EOI
        wr(1'b0, 8'h61);
        rd(1'b0, 8'h08, "R9 clear bit 1 only");
        check("R7 line 5 still blocked", 8'(irq_out), 8'h00);
        wr(1'b0, 8'h63);
        check("R9 clear bit 3 unblocks", 8'(irq_out), 8'h01);
        ack(8'h35, "R3 vector line 5");
        rd(1'b0, 8'h20, "R8 in-service line 5");

        // R4 mask, R11 spurious with line 7 masked
        irq_lines = 8'h00;
        cyc();
        wr(1'b1, 8'h84);
        irq_lines = 8'h04;
        cyc();
        check("R4 masked line quiet", 8'(irq_out), 8'h00);
        rd(1'b1, 8'h84, "R4 mask readback");
        ack(8'h37, "R11 spurious vector");
        rd(1'b0, 8'h20, "R11 in-service unchanged");
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h04, "R11 pending unchanged");

        // R12 acknowledge + EOI + fresh edge in one cycle
        wr(1'b1, 8'h00);
        check("R7 unmasked line 2", 8'(irq_out), 8'h01);
        irq_lines = 8'h00;
        cyc();
        irq_lines = 8'h04;
        bus_sel = 1'b0; bus_wdata = 8'h65; bus_wr = 1'b1;
        ack(8'h32, "R12 vector line 2");
        bus_wr = 1'b0;
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h04, "R12 in-service merge");
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h04, "R12 edge relatched");
        check("R7 equal priority blocked", 8'(irq_out), 8'h00);

        // R10 auto EOI, R3 wrap
        wr(1'b0, 8'h11);
        wr(1'b1, 8'hFC);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h03);
        check("R7 pending after reconfig", 8'(irq_out), 8'h01);
        ack(8'hFE, "R3 vector base FC line 2");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h00, "R10 no in-service bit");
        irq_lines = 8'h84;
        cyc();
        ack(8'h03, "R3 vector wraps");
        rd(1'b0, 8'h00, "R10 still empty");
        ack(8'h03, "R11 spurious auto mode");
        wr(1'b0, 8'h0C);
        rd(1'b0, 8'h02, "R2 slave cascade readback");
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h00, "R11 nothing pending");
        cyc();
        cyc();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule